// File: doc/BRIEF.md
# MDIO Management Master Controller

This block lets a host processor manage external Ethernet PHY devices over the two-wire clause-22 management interface. The host sees six word-wide registers on a simple single-cycle register bus: configuration, command, address, transmit data, receive status and an indicator. The block turns each accepted request into a 64-bit management frame on the MDC and MDIO pins. It drives MDC from a programmable divider of the system clock and switches the MDIO output enable off for the part of a read frame that the PHY drives.

A write transaction starts as soon as the host stores a value in the transmit data register. A read transaction starts only when bit 0 of the command register changes from 0 to 1, so the host first clears that bit and then sets it. The indicator register has separate busy and not-valid flags. The host polls these flags and then takes the read result from the status register. Setting the reset bit in the configuration register aborts any frame in progress. The next configuration write clears the reset bit and loads the MDC rate.

Top module: `mdio_master`

## Requirements
- R1: After the synchronous reset, the indicator register reads 0, MDC and the MDIO output enable are low, and the configuration register reads back the default half-period of 20 system clocks.
- R2: A write to the transmit data register (offset 3) while idle starts a write frame. The frame is 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10 and the 16 data bits, sent MSB first. The output enable stays high for all 64 bits.
- R3: A read starts only when a write to the command register (offset 1) changes its stored bit 0 from 0 to 1. A write of 1 while the stored bit is already 1 starts nothing.
- R4: A read frame carries opcode 10. The output enable is low for its last 18 bits (turnaround and data). The block samples the line on each rising MDC edge of the 16 data bits. When the frame ends, the captured value appears in the status register (offset 4).
- R5: Indicator bit 0 (busy) is set from the cycle a request is accepted until the frame ends. Indicator bit 1 (not-valid) is set from the start of a read until its data has been captured, and both flags read 0 afterwards.
- R6: While busy is set, writes to the transmit data register and 0-to-1 changes of the command bit start no transaction and do not alter the frame in progress.
- R7: While the stored configuration bit 31 is 1, the sequencer is held idle. Busy and not-valid are clear, MDC and the output enable are low, and no request is accepted. A later configuration write with bit 31 clear re-enables the block.
- R8: Each MDC high phase and each MDC low phase lasts N system clocks, where N is configuration bits [7:0]. A value of 0 acts as 1.
- R9: The address register (offset 2) holds the PHY address in bits [12:8] and the register number in bits [4:0], and reads back as written.
- R10: MDC and the output enable are low whenever no transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = block drives the line) |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The bench keeps the default divider width and the default half-period of 20 clocks. It measures one MDC period at that default (40 clocks) before it reprograms the divider to 2, so the whole table of frames runs at 256 clocks per frame. It also programs a divider of 0 to reach the degenerate one-clock half-period. The short frames leave room to abort a read in mid-frame and to attempt starts while busy, each followed by a check that the line goes quiet.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS  = 64;
  localparam int HDR_BITS    = 46;
  localparam int RD_DATA_IDX = 48;
  localparam int DATA_BITS   = 16;
  localparam int PHY_BITS    = 5;

  typedef enum logic [2:0] {
    OFS_CFG   = 3'd0,
    OFS_CMD   = 3'd1,
    OFS_ADDR  = 3'd2,
    OFS_TXD   = 3'd3,
    OFS_RXD   = 3'd4,
    OFS_FLAGS = 3'd5
  } reg_ofs_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_st_e;

  typedef struct packed {
    logic                 rd;
    logic [PHY_BITS-1:0]  phy;
    logic [PHY_BITS-1:0]  regn;
    logic [DATA_BITS-1:0] wdata;
  } mgmt_req_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            run,
  input  logic [DIVW-1:0] half,
  output logic            tick
);
  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] lim;

  always_comb begin
    if (half == '0) lim = '0;
    else            lim = half - 1'b1;
  end

  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (clr || !run)      cnt <= '0;
    else if (cnt >= lim)  cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 start,
  input  mgmt_req_t            req,
  input  logic                 tick,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 nvld,
  output logic                 mdc,
  output logic                 mdo,
  output logic                 oe,
  output logic [DATA_BITS-1:0] rxd
);
  localparam int IDXW = $clog2(FRAME_BITS);

  seq_st_e               st;
  logic [FRAME_BITS-1:0] sh;
  logic [IDXW-1:0]       bitn;
  logic                  phase;
  logic                  is_rd;
  logic                  oe_q;
  logic                  nvld_q;
  logic                  mdc_q;
  logic [DATA_BITS-1:0]  cap;
  logic [DATA_BITS-1:0]  rxd_q;
  logic [FRAME_BITS-1:0] frame;

  always_comb begin
    frame = {{32{1'b1}}, 2'b01,
             (req.rd ? 2'b10 : 2'b01),
             req.phy, req.regn,
             (req.rd ? 2'b11 : 2'b10),
             (req.rd ? {DATA_BITS{1'b1}} : req.wdata)};
  end

  assign busy = (st == SEQ_RUN);
  assign nvld = nvld_q;
  assign mdc  = mdc_q;
  assign mdo  = sh[FRAME_BITS-1];
  assign oe   = oe_q;
  assign rxd  = rxd_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      st     <= SEQ_IDLE;
      sh     <= '1;
      bitn   <= '0;
      phase  <= 1'b0;
      is_rd  <= 1'b0;
      oe_q   <= 1'b0;
      nvld_q <= 1'b0;
      mdc_q  <= 1'b0;
      cap    <= '0;
    end else if (st == SEQ_IDLE) begin
      if (start) begin
        st     <= SEQ_RUN;
        sh     <= frame;
        bitn   <= '0;
        phase  <= 1'b0;
        is_rd  <= req.rd;
        oe_q   <= 1'b1;
        nvld_q <= req.rd;
        mdc_q  <= 1'b0;
      end
    end else if (tick) begin
      if (!phase) begin
        mdc_q <= 1'b1;
        phase <= 1'b1;
        if (is_rd && (bitn >= IDXW'(RD_DATA_IDX)))
          cap <= {cap[DATA_BITS-2:0], mdio_i};
      end else begin
        mdc_q <= 1'b0;
        phase <= 1'b0;
        if (bitn == IDXW'(FRAME_BITS-1)) begin
          st     <= SEQ_IDLE;
          oe_q   <= 1'b0;
          nvld_q <= 1'b0;
          sh     <= '1;
        end else begin
          bitn <= bitn + 1'b1;
          sh   <= {sh[FRAME_BITS-2:0], 1'b1};
          oe_q <= !(is_rd && (bitn >= IDXW'(HDR_BITS-1)));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rxd_q <= '0;
    end else if (st == SEQ_RUN && tick && phase && is_rd &&
                 bitn == IDXW'(FRAME_BITS-1)) begin
      rxd_q <= cap;
    end
  end
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_pkg::*;
#(
  parameter int DIVW     = 8,
  parameter int DEF_HALF = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_valid,
  input  logic                 bus_we,
  input  logic [2:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 busy,
  input  logic                 nvld,
  input  logic [DATA_BITS-1:0] rxd,
  output logic [DIVW-1:0]      half,
  output logic                 soft_rst,
  output logic                 start,
  output mgmt_req_t            req
);
  logic [DIVW-1:0]      half_q;
  logic                 srst_q;
  logic                 cmd_q;
  logic [PHY_BITS-1:0]  phy_q;
  logic [PHY_BITS-1:0]  regn_q;
  logic [DATA_BITS-1:0] txd_q;
  logic                 wr_cfg, wr_cmd, wr_addr, wr_txd, rd_en;
  logic                 rd_edge;
  logic                 unused_hi;

  assign unused_hi = ^bus_wdata[30:DATA_BITS];

  assign wr_cfg  = bus_valid && bus_we && (bus_addr == OFS_CFG);
  assign wr_cmd  = bus_valid && bus_we && (bus_addr == OFS_CMD);
  assign wr_addr = bus_valid && bus_we && (bus_addr == OFS_ADDR);
  assign wr_txd  = bus_valid && bus_we && (bus_addr == OFS_TXD);
  assign rd_en   = bus_valid && !bus_we;
  assign rd_edge = wr_cmd && bus_wdata[0] && !cmd_q;

  assign start     = !busy && !srst_q && (wr_txd || rd_edge);
  assign req.rd    = !wr_txd;
  assign req.phy   = phy_q;
  assign req.regn  = regn_q;
  assign req.wdata = bus_wdata[DATA_BITS-1:0];
  assign half      = half_q;
  assign soft_rst  = srst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= DIVW'(DEF_HALF);
      srst_q <= 1'b0;
      cmd_q  <= 1'b0;
      phy_q  <= '0;
      regn_q <= '0;
      txd_q  <= '0;
    end else begin
      if (wr_cfg) begin
        srst_q <= bus_wdata[31];
        half_q <= bus_wdata[DIVW-1:0];
      end
      if (wr_cmd)  cmd_q <= bus_wdata[0];
      if (wr_addr) begin
        phy_q  <= bus_wdata[8 +: PHY_BITS];
        regn_q <= bus_wdata[0 +: PHY_BITS];
      end
      if (wr_txd)  txd_q <= bus_wdata[DATA_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      case (bus_addr)
        OFS_CFG:   bus_rdata <= {srst_q, {(31-DIVW){1'b0}}, half_q};
        OFS_CMD:   bus_rdata <= {31'd0, cmd_q};
        OFS_ADDR:  bus_rdata <= {19'd0, phy_q, 3'd0, regn_q};
        OFS_TXD:   bus_rdata <= {16'd0, txd_q};
        OFS_RXD:   bus_rdata <= {16'd0, rxd};
        OFS_FLAGS: bus_rdata <= {30'd0, nvld, busy};
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIVW     = 8,
  parameter int DEF_HALF = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_valid,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                 busy_w;
  logic                 nvld_w;
  logic                 srst_w;
  logic                 start_w;
  logic                 tick_w;
  logic                 clr_w;
  logic [DIVW-1:0]      half_w;
  logic [DATA_BITS-1:0] rxd_w;
  mgmt_req_t            req_w;

  assign clr_w = rst || srst_w;

  mdio_regfile #(.DIVW(DIVW), .DEF_HALF(DEF_HALF)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy_w),
    .nvld      (nvld_w),
    .rxd       (rxd_w),
    .half      (half_w),
    .soft_rst  (srst_w),
    .start     (start_w),
    .req       (req_w)
  );

  mdio_clkdiv #(.DIVW(DIVW)) u_div (
    .clk  (clk),
    .clr  (clr_w),
    .run  (busy_w),
    .half (half_w),
    .tick (tick_w)
  );

  mdio_frame_seq u_seq (
    .clk    (clk),
    .clr    (clr_w),
    .start  (start_w),
    .req    (req_w),
    .tick   (tick_w),
    .mdio_i (mdio_i),
    .busy   (busy_w),
    .nvld   (nvld_w),
    .mdc    (mdc),
    .mdo    (mdio_o),
    .oe     (mdio_oe),
    .rxd    (rxd_w)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic nvld,
  input logic srst,
  input logic mdc,
  input logic mdio_oe
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe)); // R10

  AST_NVLD_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst)
    nvld |-> busy); // R5

  AST_SOFT_RESET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    srst |=> (!busy && !nvld)); // R7

  AST_WRITE_DRIVES_ALL: assert property (@(posedge clk) disable iff (rst)
    (busy && !nvld) |-> mdio_oe); // R2

  AST_START_MDC_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !mdc); // R8
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy_w),
  .nvld    (nvld_w),
  .srst    (srst_w),
  .mdc     (mdc),
  .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_drv = 1'b0, phy_bit = 1'b0, phy_rd = 1'b0;
  logic [15:0] phy_data = '0;
  logic [63:0] rx = '0, oes = '0;
  int          nrise = 0, arm = 0, arm_seen = 0, cyc = 0;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;
  wire         mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  mdio_master dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  always #5 clk = ~clk;
  always @(negedge clk) cyc++;

  always @(posedge mdc) begin
    if (arm != arm_seen) begin nrise = 0; arm_seen = arm; end
    if (nrise < 64) begin
      rx[63-nrise]  = mdio_line;
      oes[63-nrise] = mdio_oe;
    end
    nrise++;
  end

  always @(negedge mdc) begin
    if (phy_rd && nrise >= 47 && nrise <= 63) begin
      phy_drv = 1'b1;
      phy_bit = (nrise == 47) ? 1'b0 : phy_data[63-nrise];
    end else begin
      phy_drv = 1'b0;
    end
  end

  localparam int NV = 6;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 5'd1,  5'd0,  16'h1340},
    {1'b1, 5'd1,  5'd2,  16'h0141},
    {1'b0, 5'd31, 5'd31, 16'hFFFF},
    {1'b1, 5'd0,  5'd1,  16'h0000},
    {1'b0, 5'd0,  5'd0,  16'h0001},
    {1'b1, 5'd17, 5'd9,  16'h8001}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
  endfunction

  task automatic wait_frame(input int h);
    repeat (128*h + 8) @(posedge clk);
  endtask

  initial begin
    logic [31:0] d;
    int c0, c1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    bus_rd(3'd5, d); chk("R1 flags", d, 0);
    bus_rd(3'd0, d); chk("R1 cfg default", d, 32'd20);
    chk("R1 mdc/oe", {mdc, mdio_oe}, 2'b00);

    bus_wr(3'd2, 32'h0000_0305);
    arm++; phy_rd = 1'b0;
    bus_wr(3'd3, 32'h0000_ABCD);
    @(posedge mdc); c0 = cyc;
    @(posedge mdc); c1 = cyc;
    chk("R8 default period", c1 - c0, 40);
    wait_frame(20);
    chk("R2 frame at default", rx, exp_frame(1'b0, 5'd3, 5'd5, 16'hABCD));

    bus_wr(3'd0, 32'd2);
    for (int i = 0; i < NV; i++) begin
      logic rd; logic [4:0] p, r; logic [15:0] v;
      {rd, p, r, v} = VEC[i];
      bus_wr(3'd2, {19'd0, p, 3'd0, r});
      bus_rd(3'd2, d); chk("R9 addr readback", d, {19'd0, p, 3'd0, r});
      arm++;
      if (!rd) begin
        phy_rd = 1'b0;
        bus_wr(3'd3, {16'd0, v});
        bus_rd(3'd5, d); chk("R5 busy during write", d, 32'd1);
        wait_frame(2);
        bus_rd(3'd5, d); chk("R5 idle after write", d, 0);
        chk("R2 write frame", rx, exp_frame(1'b0, p, r, v));
        chk("R2 oe all bits", oes, {64{1'b1}});
      end else begin
        phy_rd = 1'b1; phy_data = v;
        bus_wr(3'd1, 32'd0);
        bus_wr(3'd1, 32'd1);
        bus_rd(3'd5, d); chk("R5 busy+notvalid during read", d, 32'd3);
        wait_frame(2);
        bus_rd(3'd5, d); chk("R5 idle after read", d, 0);
        bus_rd(3'd4, d); chk("R4 read data", d, {16'd0, v});
        chk("R4 read header", rx[63:18], exp_frame(1'b1, p, r, v) >> 18);
        chk("R4 oe release", oes, {{46{1'b1}}, 18'd0});
      end
      chk("R10 quiet between frames", {mdc, mdio_oe}, 2'b00);
    end

    bus_wr(3'd1, 32'd1);
    bus_rd(3'd5, d); chk("R3 no start on level", d, 0);

    phy_rd = 1'b0; arm++;
    bus_wr(3'd2, 32'h0000_0402);
    bus_wr(3'd3, 32'h0000_5A5A);
    bus_wr(3'd3, 32'h0000_1111);
    bus_wr(3'd1, 32'd0);
    bus_wr(3'd1, 32'd1);
    wait_frame(2);
    bus_rd(3'd5, d); chk("R6 no extra transaction", d, 0);
    chk("R6 frame unchanged", rx, exp_frame(1'b0, 5'd4, 5'd2, 16'h5A5A));

    phy_rd = 1'b1; phy_data = 16'hC3C3; arm++;
    bus_wr(3'd1, 32'd0);
    bus_wr(3'd1, 32'd1);
    repeat (100) @(posedge clk);
    bus_wr(3'd0, 32'h8000_0002);
    bus_rd(3'd5, d); chk("R7 abort flags", d, 0);
    chk("R7 abort pins", {mdc, mdio_oe}, 2'b00);
    bus_wr(3'd3, 32'h0000_7777);
    bus_rd(3'd5, d); chk("R7 start blocked", d, 0);
    bus_wr(3'd0, 32'd0);
    phy_rd = 1'b0; arm++;
    bus_wr(3'd2, 32'h0000_0107);
    bus_wr(3'd3, 32'h0000_0F0F);
    @(posedge mdc); c0 = cyc;
    @(posedge mdc); c1 = cyc;
    chk("R8 zero divider", c1 - c0, 2);
    wait_frame(1);
    chk("R7 works after release", rx, exp_frame(1'b0, 5'd1, 5'd7, 16'h0F0F));
    bus_rd(3'd5, d); chk("R5 idle at end", d, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule